// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer for a 10-bit successive-approximation converter. Software sets a start/busy bit, or a qualified external trigger sets it. The block then runs an optional automatic acquisition phase with the sample-and-hold connected. After that it runs one setup period and resolves the result from the most significant bit down, one bit per conversion-clock enable. It does this by driving a trial code to the DAC and reading a single comparator bit.

When a conversion finishes, the block does four things on one clock edge: it latches the result, drops the busy bit, raises the interrupt flag and reconnects the sample-and-hold. Software can cancel a conversion by writing the busy bit to zero. A cancelled conversion leaves the stored result alone. After a conversion finishes or is cancelled, a fixed recovery wait of two conversion-clock periods must pass before another acquisition can begin. A start request made during that wait is held and begins once the wait ends.

The conversion-clock divider, the comparator and the DAC sit outside the block. The block sees them as an enable pulse, a comparator input and a trial-code output.

Top module: `sar_adc_sequencer`

## Requirements
- R1: After reset, busy_o, irq_o, timer_rst_o and result_o are all zero, and sh_connect_o is one.
- R2: A write of one to the busy bit (go_wr_i with go_wdata_i=1) starts a conversion only while en_i is high. While en_i is low, the write is ignored and busy_o stays low.
- R3: The acquisition length in enable pulses depends on acq_sel_i: 0→0, 1→2, 2→4, 3→6, 4→8, 5→12, 6→16, 7→20. With code 0, the conversion phase begins on the clock after the start. The enable pulse seen on the start clock is not counted.
- R4: sh_connect_o stays high during acquisition. It is low for exactly the 11 enable pulses of the conversion phase (one setup pulse plus 10 bit decisions). So a conversion holds busy_o high across acquisition-length + 11 pulses.
- R5: Bits are decided from bit 9 down to bit 0. Each step sets the trial bit on trial_o. The next enable pulse keeps the bit when cmp_i is 1, meaning the input is at or above the trial code. With an ideal comparator, result_o equals the input level.
- R6: When a conversion completes, the same edge loads result_o, clears busy_o, sets irq_o and raises sh_connect_o.
- R7: An abort ends the current acquisition or conversion. An abort is a write of zero to the busy bit, or en_i falling while busy. An abort leaves result_o unchanged, does not set irq_o, and clears busy_o on the next edge.
- R8: res_wr_i loads res_wdata_i into result_o on the next edge. That value is held through any later abort.
- R9: After completion or abort, 2 enable pulses of recovery pass before acquisition may begin. A start requested during recovery keeps busy_o high and begins automatically when recovery ends.
- R10: trig_i with trig_mode_i = 4'b1011 pulses timer_rst_o high for exactly one clock on the next edge. If en_i is high, the same trigger also starts a conversion like a software start.
- R11: With en_i low, a matching trigger still pulses timer_rst_o but starts nothing. A trigger with any other mode value does neither.
- R12: irq_clr_i clears irq_o on the next edge. A completion on the same edge takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable |
| go_wr_i | input | 1 | Software write strobe for the busy bit |
| go_wdata_i | input | 1 | Value written to the busy bit (1 start, 0 abort) |
| acq_sel_i | input | 3 | Automatic acquisition length select |
| tad_tick_i | input | 1 | One-clock conversion-clock enable pulse |
| cmp_i | input | 1 | Comparator: input at or above trial code |
| trig_i | input | 1 | External trigger event |
| trig_mode_i | input | 4 | Trigger mode field, 4'b1011 arms the start |
| res_wr_i | input | 1 | Software write strobe for the result |
| res_wdata_i | input | 10 | Value written to the result |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| busy_o | output | 1 | Busy bit (start/done status) |
| sh_connect_o | output | 1 | Sample-and-hold connected to input |
| trial_o | output | 10 | Trial code to the DAC |
| result_o | output | 10 | Result register |
| irq_o | output | 1 | Conversion-complete flag |
| timer_rst_o | output | 1 | One-clock timer reset pulse |

## Verification
A wrong acquisition count or a wrong recovery count leaves no mark on the result. It shows at the ports only as busy_o staying high for a different number of enable pulses. The bench therefore counts enable pulses while busy_o is high, and the counts are exact because starts are aligned to the pulse phase. A fault in the bit-decision path, such as a wrong step index, order or comparator polarity, shows in result_o on the completion edge of the first conversion whose input level uses that bit. The sweep over every input level catches it within one conversion. Mistakes in abort handling show as result_o or irq_o changing on the cancel edge. A mistake in the recovery wait shows as a pulse count that is off by one on the next start.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   localparam int ACQ_CODE_W = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_ACQ,
      ST_CONV,
      ST_RECOV
   } seq_state_t;

   // automatic acquisition length, in conversion-clock enable pulses
   function automatic int unsigned acq_tads(input logic [ACQ_CODE_W-1:0] code);
      case (code)
         3'd0:    return 0;
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 6;
         3'd4:    return 8;
         3'd5:    return 12;
         3'd6:    return 16;
         default: return 20;
      endcase
   endfunction

endpackage

// File: rtl/sar_tad_counter.sv
module sar_tad_counter #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (tick && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sar_trig_gate.sv
module sar_trig_gate #(
   parameter int                MODE_W    = 4,
   parameter logic [MODE_W-1:0] TRIG_MODE = 'hB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              trig,
   input  logic [MODE_W-1:0] mode,
   output logic              start,
   output logic              timer_rst
);

   logic armed;

   assign armed = trig && (mode == TRIG_MODE);
   assign start = armed && en;

   // the timer reset does not depend on the enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         timer_rst <= 1'b0;
      else
         timer_rst <= armed;
   end

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
   parameter int RES_W  = 10,
   parameter int STEP_W = $clog2(RES_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic             tick,
   input  logic             cmp,
   input  logic             sw_wr,
   input  logic [RES_W-1:0] sw_data,
   output logic [RES_W-1:0] trial,
   output logic [RES_W-1:0] result,
   output logic             done
);

   logic [STEP_W-1:0] step_q;
   logic [RES_W-1:0]  trial_q;
   logic [RES_W-1:0]  trial_nxt;
   logic              active_q;
   logic              adv;

   // per bit: decided from the comparator, set as the new trial, or held
   for (genvar i = 0; i < RES_W; i++) begin : g_slice
      assign trial_nxt[i] = (step_q == STEP_W'(RES_W - i))     ? cmp  :
                            (step_q == STEP_W'(RES_W - 1 - i)) ? 1'b1 :
                                                                 trial_q[i];
   end

   assign adv  = active_q && tick;
   assign done = adv && (step_q == STEP_W'(RES_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         step_q   <= '0;
         trial_q  <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         step_q   <= '0;
         trial_q  <= '0;
      end else if (abort || done) begin
         active_q <= 1'b0;
         step_q   <= '0;
         trial_q  <= '0;
      end else if (adv) begin
         step_q  <= step_q + 1'b1;
         trial_q <= trial_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         result <= '0;
      else if (done)
         result <= trial_nxt;
      else if (sw_wr)
         result <= sw_data;
   end

   assign trial = trial_q;

endmodule

// File: rtl/sar_adc_sequencer.sv
module sar_adc_sequencer
   import sar_seq_pkg::*;
#(
   parameter int                RES_W      = 10,
   parameter int                MODE_W     = 4,
   parameter logic [MODE_W-1:0] TRIG_MODE  = 'hB,
   parameter int                RECOV_TADS = 2,
   parameter int                CNT_W      = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en_i,
   input  logic                  go_wr_i,
   input  logic                  go_wdata_i,
   input  logic [ACQ_CODE_W-1:0] acq_sel_i,
   input  logic                  tad_tick_i,
   input  logic                  cmp_i,
   input  logic                  trig_i,
   input  logic [MODE_W-1:0]     trig_mode_i,
   input  logic                  res_wr_i,
   input  logic [RES_W-1:0]      res_wdata_i,
   input  logic                  irq_clr_i,
   output logic                  busy_o,
   output logic                  sh_connect_o,
   output logic [RES_W-1:0]      trial_o,
   output logic [RES_W-1:0]      result_o,
   output logic                  irq_o,
   output logic                  timer_rst_o
);

   localparam int MAX_ACQ = 20;

   if (RES_W < 2) begin : g_chk_res
      $error("RES_W must be at least 2");
   end
   if ((2 ** CNT_W) <= MAX_ACQ || (2 ** CNT_W) <= RECOV_TADS) begin : g_chk_cnt
      $error("CNT_W too narrow for the longest wait");
   end
   if (RECOV_TADS < 1) begin : g_chk_rec
      $error("RECOV_TADS must be at least 1");
   end

   seq_state_t       st_q, st_d;
   logic             go_q;
   logic             trig_go;
   logic             sw_set, sw_clr, go_req, go_pend, in_flight, abort;
   logic             conv_done, eng_start, eng_abort;
   logic             cnt_ld, cnt_last;
   logic [CNT_W-1:0] cnt_ld_val, acq_len;

   sar_trig_gate #(
      .MODE_W    (MODE_W),
      .TRIG_MODE (TRIG_MODE)
   ) u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_i),
      .trig      (trig_i),
      .mode      (trig_mode_i),
      .start     (trig_go),
      .timer_rst (timer_rst_o)
   );

   assign acq_len   = CNT_W'(acq_tads(acq_sel_i));
   assign sw_set    = go_wr_i && go_wdata_i;
   assign sw_clr    = go_wr_i && !go_wdata_i;
   assign go_req    = en_i && !sw_clr && (sw_set || trig_go);
   assign go_pend   = go_req || (go_q && en_i && !sw_clr);
   assign in_flight = (st_q == ST_START) || (st_q == ST_ACQ) || (st_q == ST_CONV);
   assign abort     = in_flight && (sw_clr || !en_i);

   always_comb begin
      st_d       = st_q;
      cnt_ld     = 1'b0;
      cnt_ld_val = acq_len;
      unique case (st_q)
         ST_IDLE: begin
            if (go_pend) begin
               if (acq_len == '0) begin
                  st_d = ST_START;
               end else begin
                  st_d   = ST_ACQ;
                  cnt_ld = 1'b1;
               end
            end
         end
         ST_START: st_d = abort ? ST_RECOV : ST_CONV;
         ST_ACQ: begin
            if (abort)
               st_d = ST_RECOV;
            else if (tad_tick_i && cnt_last)
               st_d = ST_CONV;
         end
         ST_CONV: begin
            if (abort || conv_done)
               st_d = ST_RECOV;
         end
         ST_RECOV: begin
            if (tad_tick_i && cnt_last) begin
               if (!go_pend) begin
                  st_d = ST_IDLE;
               end else if (acq_len == '0) begin
                  st_d = ST_START;
               end else begin
                  st_d   = ST_ACQ;
                  cnt_ld = 1'b1;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
      if (st_d == ST_RECOV && st_q != ST_RECOV) begin
         cnt_ld     = 1'b1;
         cnt_ld_val = CNT_W'(RECOV_TADS);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= ST_IDLE;
      else
         st_q <= st_d;
   end

   sar_tad_counter #(
      .CNT_W (CNT_W)
   ) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_ld),
      .load_val (cnt_ld_val),
      .tick     (tad_tick_i),
      .last     (cnt_last)
   );

   assign eng_start = (st_d == ST_CONV) && (st_q != ST_CONV);
   assign eng_abort = (st_q == ST_CONV) && abort;

   sar_bit_engine #(
      .RES_W (RES_W)
   ) u_sar (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (eng_start),
      .abort   (eng_abort),
      .tick    (tad_tick_i),
      .cmp     (cmp_i),
      .sw_wr   (res_wr_i),
      .sw_data (res_wdata_i),
      .trial   (trial_o),
      .result  (result_o),
      .done    (conv_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         go_q <= 1'b0;
      else if (!en_i || sw_clr || conv_done)
         go_q <= 1'b0;
      else if (go_req)
         go_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_o <= 1'b0;
      else if (conv_done)
         irq_o <= 1'b1;
      else if (irq_clr_i)
         irq_o <= 1'b0;
   end

   assign busy_o       = go_q;
   assign sh_connect_o = (st_q != ST_CONV);

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
   parameter int                RES_W     = 10,
   parameter int                MODE_W    = 4,
   parameter logic [MODE_W-1:0] TRIG_MODE = 'hB
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_i,
   input logic              go_wr_i,
   input logic              go_wdata_i,
   input logic              trig_i,
   input logic [MODE_W-1:0] trig_mode_i,
   input logic              res_wr_i,
   input logic              busy_o,
   input logic              sh_connect_o,
   input logic [RES_W-1:0]  result_o,
   input logic              irq_o,
   input logic              timer_rst_o
);

   // R2
   disabled_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !busy_o) |=> !busy_o);

   // R4
   hold_open_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_connect_o |-> busy_o);

   // R6
   flag_with_completion_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($fell(busy_o) && sh_connect_o));

   // R7
   sw_abort_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go_wr_i && !go_wdata_i) |=> !busy_o);

   // R8
   result_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_wr_i && !(busy_o && !sh_connect_o)) |=> $stable(result_o));

   // R10
   timer_pulse_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && trig_mode_i == TRIG_MODE) |=> timer_rst_o);

   // R11
   no_timer_pulse_otherwise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(trig_i && trig_mode_i == TRIG_MODE) |=> !timer_rst_o);

endmodule

bind sar_adc_sequencer sar_seq_chk #(
   .RES_W     (RES_W),
   .MODE_W    (MODE_W),
   .TRIG_MODE (TRIG_MODE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .en_i         (en_i),
   .go_wr_i      (go_wr_i),
   .go_wdata_i   (go_wdata_i),
   .trig_i       (trig_i),
   .trig_mode_i  (trig_mode_i),
   .res_wr_i     (res_wr_i),
   .busy_o       (busy_o),
   .sh_connect_o (sh_connect_o),
   .result_o     (result_o),
   .irq_o        (irq_o),
   .timer_rst_o  (timer_rst_o)
);

// File: tb/sim_sar_adc_sequencer.sv
`timescale 1ns / 100ps
module sim_sar_adc_sequencer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_i = 1'b0;
   logic       go_wr_i = 1'b0;
   logic       go_wdata_i = 1'b0;
   logic [2:0] acq_sel_i = 3'd0;
   logic       tad_tick_i = 1'b0;
   logic       cmp_i;
   logic       trig_i = 1'b0;
   logic [3:0] trig_mode_i = 4'd0;
   logic       res_wr_i = 1'b0;
   logic [9:0] res_wdata_i = 10'd0;
   logic       irq_clr_i = 1'b0;
   logic       busy_o, sh_connect_o, irq_o, timer_rst_o;
   logic [9:0] trial_o, result_o;

   int  vin = 0;
   int  ph = 0;
   int  tcnt = 0, acnt = 0;
   int  n_chk = 0, n_fail = 0;
   bit  finished = 0;
   bit  p_gowr = 0, p_godat = 0, p_trig = 0, p_reswr = 0, p_irqclr = 0;

   always #2.5 clk = ~clk;

   assign cmp_i = (vin >= int'(trial_o));

   sar_adc_sequencer u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (en_i),
      .go_wr_i      (go_wr_i),
      .go_wdata_i   (go_wdata_i),
      .acq_sel_i    (acq_sel_i),
      .tad_tick_i   (tad_tick_i),
      .cmp_i        (cmp_i),
      .trig_i       (trig_i),
      .trig_mode_i  (trig_mode_i),
      .res_wr_i     (res_wr_i),
      .res_wdata_i  (res_wdata_i),
      .irq_clr_i    (irq_clr_i),
      .busy_o       (busy_o),
      .sh_connect_o (sh_connect_o),
      .trial_o      (trial_o),
      .result_o     (result_o),
      .irq_o        (irq_o),
      .timer_rst_o  (timer_rst_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // one clock: sample at the falling edge, then drive this cycle's inputs
   task automatic step();
      @(negedge clk);
      ph++;
      tad_tick_i = (ph % 4 == 0);
      go_wr_i    = p_gowr;
      go_wdata_i = p_godat;
      trig_i     = p_trig;
      res_wr_i   = p_reswr;
      irq_clr_i  = p_irqclr;
      p_gowr = 0; p_godat = 0; p_trig = 0; p_reswr = 0; p_irqclr = 0;
      if (busy_o && tad_tick_i) begin
         tcnt++;
         if (sh_connect_o) acnt++;
      end
   endtask

   function automatic int acq_len(input int code);
      if (code == 0) return 0;
      if (code <= 4) return 2 * code;
      return 8 + 4 * (code - 4);
   endfunction

   task automatic wait_idle();
      for (int g = 0; g < 2000 && busy_o; g++) step();
   endtask

   // start in a cycle that carries an enable pulse, run to completion
   task automatic run(input int v, input int code);
      while (((ph + 1) % 4) != 0) step();
      vin = v;
      acq_sel_i = code[2:0];
      p_gowr = 1; p_godat = 1;
      step();
      tcnt = 0; acnt = 0;
      step();
      wait_idle();
   endtask

   initial begin
      repeat (4) step();
      rst_n = 1'b1;
      step();
      // R1 reset values
      check(busy_o == 0, "R1 busy", busy_o, 0);
      check(sh_connect_o == 1, "R1 sh_connect", sh_connect_o, 1);
      check(result_o == 0, "R1 result", result_o, 0);
      check(irq_o == 0, "R1 irq", irq_o, 0);
      check(timer_rst_o == 0, "R1 timer_rst", timer_rst_o, 0);

      // R2 start write ignored while disabled
      p_gowr = 1; p_godat = 1;
      repeat (3) step();
      check(busy_o == 0, "R2 disabled start", busy_o, 0);

      // R11 matching trigger while disabled
      trig_mode_i = 4'b1011;
      p_trig = 1;
      step(); step();
      check(timer_rst_o == 1, "R11 timer pulse disabled", timer_rst_o, 1);
      step();
      check(timer_rst_o == 0, "R11 timer pulse width", timer_rst_o, 0);
      check(busy_o == 0, "R11 no start disabled", busy_o, 0);

      // R11 wrong mode, enabled
      en_i = 1'b1;
      trig_mode_i = 4'b1010;
      p_trig = 1;
      step(); step();
      check(timer_rst_o == 0, "R11 wrong mode timer", timer_rst_o, 0);
      step();
      check(busy_o == 0, "R11 wrong mode start", busy_o, 0);

      // R10 matching trigger, enabled
      trig_mode_i = 4'b1011;
      vin = 613;
      acq_sel_i = 3'd0;
      p_trig = 1;
      step(); step();
      check(timer_rst_o == 1, "R10 timer pulse", timer_rst_o, 1);
      check(busy_o == 1, "R10 trigger start", busy_o, 1);
      wait_idle();
      check(result_o == 10'd613, "R10 triggered result", result_o, 613);
      trig_mode_i = 4'd0;
      p_irqclr = 1;
      repeat (12) step();

      // R3 R4 R5 R6 R12 sweep of every level, acquisition code cycling
      for (int v = 0; v < 1024; v++) begin
         int code = v % 8;
         run(v, code);
         check(result_o == v[9:0], "R5 result", result_o, v);
         check(irq_o == 1, "R6 irq", irq_o, 1);
         check(sh_connect_o == 1, "R6 reconnect", sh_connect_o, 1);
         check(tcnt == acq_len(code) + 11, "R3 busy pulses", tcnt, acq_len(code) + 11);
         check(acnt == acq_len(code), "R4 connected pulses", acnt, acq_len(code));
         p_irqclr = 1;
         step(); step();
         check(irq_o == 0, "R12 irq clear", irq_o, 0);
         repeat (10) step();
      end

      // R9 start requested right after completion waits out the recovery
      run(100, 0);
      p_gowr = 1; p_godat = 1; vin = 900;
      step();
      tcnt = 0;
      step();
      check(busy_o == 1, "R9 start held in recovery", busy_o, 1);
      wait_idle();
      check(tcnt == 13, "R9 recovery pulses", tcnt, 13);
      check(result_o == 10'd900, "R9 result", result_o, 900);
      p_irqclr = 1;
      repeat (12) step();

      // R8 software write, then abort during conversion
      p_reswr = 1; res_wdata_i = 10'h2AA;
      step(); step();
      check(result_o == 10'h2AA, "R8 software write", result_o, 'h2AA);
      vin = 77; acq_sel_i = 3'd3;
      while (((ph + 1) % 4) != 0) step();
      p_gowr = 1; p_godat = 1;
      step();
      repeat (40) step();
      check(sh_connect_o == 0, "R4 converting", sh_connect_o, 0);
      while (((ph + 1) % 4) != 0) step();
      p_gowr = 1; p_godat = 0;
      step(); step();
      check(busy_o == 0, "R7 abort busy", busy_o, 0);
      check(result_o == 10'h2AA, "R8 held through abort", result_o, 'h2AA);
      check(irq_o == 0, "R7 abort no irq", irq_o, 0);
      check(sh_connect_o == 1, "R7 abort reconnect", sh_connect_o, 1);
      // R9 recovery after abort
      acq_sel_i = 3'd0;
      p_gowr = 1; p_godat = 1;
      step();
      tcnt = 0;
      step();
      wait_idle();
      check(tcnt == 13, "R9 recovery after abort", tcnt, 13);
      check(result_o == 10'd77, "R5 result after abort", result_o, 77);
      p_irqclr = 1;
      repeat (12) step();

      // R7 abort by dropping the enable
      vin = 500;
      while (((ph + 1) % 4) != 0) step();
      p_gowr = 1; p_godat = 1;
      step();
      repeat (20) step();
      en_i = 1'b0;
      step(); step();
      check(busy_o == 0, "R7 disable abort busy", busy_o, 0);
      check(result_o == 10'd77, "R7 disable abort result", result_o, 77);
      check(irq_o == 0, "R7 disable abort irq", irq_o, 0);
      en_i = 1'b1;
      repeat (12) step();

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 195000, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule